// File: doc/BRIEF.md
# Flash Status Byte Generator

This block produces the byte that a byte-wide flash memory returns on a read while its embedded program or erase controller is working. Each of four status bits follows its own rule. The polling bit shows the inverse of the data bit being written. The toggle bit inverts once for every completed read. The error bit is sticky. The window bit reflects the erase-accept window. The other four bits are driven to a fixed masked value.

The command decoder outside the block reports events to it. `op_start` starts an operation, and `op_is_erase` and `target_prot` qualify it. `op_done` ends it and `fail` marks a failure. The decoder also drives the erase window level (`win_open`) and the reset-instruction clear (`clr_err`). The host read strobe `rd_en` drives the toggle bit. An erase whose every target block is protected gives a timed busy interval of `PROT_CYC` clock cycles. A program aimed at a protected block is dropped. The output `status_valid` tells the read path to return `status_o` in place of array data.

Top module: `flash_status_gen`

## Requirements
- R1: While a program is running, `status_o[7]` is the inverse of the data bit latched at `op_start`. While an erase is running, `status_o[7]` is 0.
- R2: When no operation is active, `status_o[7]` is the latched bit after a program and 1 after an erase. After reset it is 1.
- R3: While `status_valid` is 1, `status_o[6]` inverts once for each falling edge of `rd_en`. While `status_valid` is 0 it holds its value. After reset it is 0.
- R4: A read that holds `rd_en` high for many cycles causes exactly one inversion of `status_o[6]`, in the cycle after `rd_en` falls.
- R5: `fail` during a running operation sets `status_o[5]` in the next cycle. The bit stays 1 until `clr_err` clears it, and `fail` wins if both come in the same cycle. After reset it is 0.
- R6: `status_o[3]` is 0 while `win_open` is 1, and 1 otherwise, in the same cycle.
- R7: An erase started with `target_prot`=1 holds `status_valid` at 1 for exactly `PROT_CYC` cycles, beginning in the cycle after `op_start`. During that time `status_o[7]` is 0 and `status_o[6]` toggles on reads. Afterwards `status_valid` is 0 and `status_o[7]` is 1.
- R8: A program started with `target_prot`=1 is ignored. `status_valid` stays 0, `status_o[7]` keeps its value, and reads do not change `status_o[6]`.
- R9: Bits 0, 1, 2 and 4 of `status_o` always equal the parameter `MASK_BIT` (default 0).
- R10: For an unprotected operation, `status_valid` rises in the cycle after `op_start` and falls in the cycle after `op_done`. `op_start` is ignored while `status_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse that begins an operation |
| op_is_erase | input | 1 | 1 = erase, 0 = program, sampled with `op_start` |
| target_prot | input | 1 | Target block(s) protected, sampled with `op_start` |
| data_bit7 | input | 1 | Bit 7 of the byte being programmed, sampled with `op_start` |
| op_done | input | 1 | Pulse ending a running operation |
| fail | input | 1 | Pulse marking a program or erase failure |
| clr_err | input | 1 | Reset-instruction pulse that clears the error bit |
| win_open | input | 1 | Erase-accept window is waiting for the erase to start |
| rd_en | input | 1 | Host read strobe |
| status_o | output | 8 | Status byte |
| status_valid | output | 1 | Status byte replaces array data on reads |

## Verification
The assertions assume the decoder keeps its protocol. `op_done` and `fail` arrive only while an operation is running. No `op_start` comes while `status_valid` is high, although the block also guards against that case. The bench drives every pulse on the falling clock edge and issues `op_done` and `fail` only after a start it has seen accepted. It also sends one deliberately early `op_start` to show that the start is dropped. Protected-target starts are issued only from the idle state, so the timed interval and the dropped program never overlap a running operation.

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int   PROT_CYC = 50,
  parameter logic MASK_BIT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start,
  input  logic       op_is_erase,
  input  logic       target_prot,
  input  logic       data_bit7,
  input  logic       op_done,
  input  logic       fail,
  input  logic       clr_err,
  input  logic       win_open,
  input  logic       rd_en,
  output logic [7:0] status_o,
  output logic       status_valid
);
  localparam int CW = $clog2(PROT_CYC + 1);

  logic          run, kind_erase, pbit, tgl, err, rd_q;
  logic [CW-1:0] pcnt;
  logic          prot_busy, rd_fall, accept;
  logic          poll;

  assign prot_busy    = (pcnt != '0);
  assign status_valid = run | prot_busy;
  assign rd_fall      = rd_q & ~rd_en;
  assign accept       = op_start & ~status_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      kind_erase <= 1'b1;
      pbit       <= 1'b0;
      pcnt       <= '0;
    end else begin
      if (prot_busy) pcnt <= pcnt - 1'b1;
      if (run && op_done) run <= 1'b0;
      if (accept) begin
        if (op_is_erase && target_prot) begin
          pcnt       <= CW'(PROT_CYC);
          kind_erase <= 1'b1;
        end else if (!target_prot) begin
          run        <= 1'b1;
          kind_erase <= op_is_erase;
          pbit       <= data_bit7;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tgl  <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (status_valid && rd_fall) tgl <= ~tgl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              err <= 1'b0;
    else if (run && fail)    err <= 1'b1;
    else if (clr_err)        err <= 1'b0;
  end

  always_comb begin
    if (run)            poll = kind_erase ? 1'b0 : ~pbit;
    else if (prot_busy) poll = 1'b0;
    else                poll = kind_erase ? 1'b1 : pbit;
  end

  assign status_o = {poll, tgl, err, MASK_BIT, ~win_open, MASK_BIT, MASK_BIT, MASK_BIT};

  p_erase_poll_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kind_erase) |-> !status_o[7]);

  p_toggle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !status_valid |=> $stable(status_o[6]));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5] && !clr_err) |=> status_o[5]);

  p_prot_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && !run) |-> !status_o[7]);

  p_prot_prog_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !op_is_erase && target_prot && !status_valid) |=> !status_valid);

  p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op_done && !prot_busy) |=> !status_valid);
endmodule

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int PROT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, op_is_erase = 0, target_prot = 0, data_bit7 = 0;
  logic op_done = 0, fail = 0, clr_err = 0, win_open = 0, rd_en = 0;
  logic [7:0] status_o;
  logic       status_valid;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  flash_status_gen #(.PROT_CYC(PROT), .MASK_BIT(1'b0)) i_flash_status_gen (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
    .target_prot(target_prot), .data_bit7(data_bit7), .op_done(op_done),
    .fail(fail), .clr_err(clr_err), .win_open(win_open), .rd_en(rd_en),
    .status_o(status_o), .status_valid(status_valid));

  always #2 clk = ~clk;

  // behavioural reference
  bit m_run = 0, m_erase = 1, m_bit = 0, m_t = 0, m_err = 0, m_rdq = 0;
  int m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run <= 0; m_erase <= 1; m_bit <= 0; m_t <= 0; m_err <= 0; m_rdq <= 0; m_cnt <= 0;
    end else begin
      bit act;
      act = m_run || (m_cnt > 0);
      m_rdq <= rd_en;
      if (act && m_rdq && !rd_en) m_t <= !m_t;
      if (m_run && fail) m_err <= 1;
      else if (clr_err) m_err <= 0;
      if (m_cnt > 0) m_cnt <= m_cnt - 1;
      if (m_run && op_done) m_run <= 0;
      if (op_start && !act) begin
        if (op_is_erase && target_prot) begin m_cnt <= PROT; m_erase <= 1; end
        else if (!target_prot) begin m_run <= 1; m_erase <= op_is_erase; m_bit <= data_bit7; end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      bit act;
      bit e7;
      act = m_run || (m_cnt > 0);
      if (m_run)          e7 = m_erase ? 1'b0 : !m_bit;
      else if (m_cnt > 0) e7 = 1'b0;
      else                e7 = m_erase ? 1'b1 : m_bit;
      chk("R1 R2 R7 poll bit7", {7'd0, status_o[7]}, {7'd0, e7});
      chk("R3 R4 toggle bit6", {7'd0, status_o[6]}, {7'd0, m_t});
      chk("R5 error bit5", {7'd0, status_o[5]}, {7'd0, m_err});
      chk("R6 window bit3", {7'd0, status_o[3]}, {7'd0, !win_open});
      chk("R9 masked bits", {4'd0, status_o[4], status_o[2:0]}, 8'd0);
      chk("R7 R8 R10 status_valid", {7'd0, status_valid}, {7'd0, act});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_start(input bit er, input bit pr, input bit d);
    op_start = 1; op_is_erase = er; target_prot = pr; data_bit7 = d;
    tick(1);
    op_start = 0; op_is_erase = 0; target_prot = 0; data_bit7 = 0;
  endtask

  task automatic do_read(input int len);
    rd_en = 1; tick(len); rd_en = 0; tick(1);
  endtask

  initial begin
    tick(3);
    // reset state: R2 bit7=1, R3 bit6=0, R5 bit5=0
    chk("R2 reset bit7", {7'd0, status_o[7]}, 8'd1);
    chk("R3 reset bit6", {7'd0, status_o[6]}, 8'd0);
    rst_n = 1; tick(2);
    // program of a 1 with short and long reads (R1, R3, R4, R10)
    pulse_start(0, 0, 1);
    do_read(1); do_read(1); do_read(7);
    pulse_start(1, 0, 0);           // R10: ignored while busy
    fail = 1; tick(1); fail = 0;    // R5
    tick(2);
    op_done = 1; tick(1); op_done = 0; tick(2);
    do_read(2);                     // R3: idle read no toggle
    // erase with window (R1, R6)
    win_open = 1; tick(2);
    pulse_start(1, 0, 0);
    tick(3); win_open = 0;
    do_read(3); do_read(1);
    op_done = 1; tick(1); op_done = 0; tick(2);
    clr_err = 1; tick(1); clr_err = 0; tick(1);   // R5 clear
    // program of a 0, fail and clear together (R5 fail wins)
    pulse_start(0, 0, 0);
    fail = 1; clr_err = 1; tick(1); fail = 0; clr_err = 0;
    do_read(2);
    op_done = 1; tick(1); op_done = 0; tick(2);
    // protected program ignored (R8)
    pulse_start(0, 1, 1);
    do_read(1); do_read(4); tick(2);
    // protected erase interval (R7)
    pulse_start(1, 1, 0);
    do_read(1); do_read(2); do_read(1);
    tick(PROT + 3);
    do_read(1);
    clr_err = 1; tick(1); clr_err = 0; tick(3);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule